// File: doc/BRIEF.md
# Dual-Port Semaphore Bank

This block holds a small bank of hardware semaphore latches that two independent ports, left and right, share in order to reserve common resources. The latches sit apart from any memory array. Each port reaches them through its own active-low semaphore select, which is honoured only while that port's memory chip enable is held inactive. The low address bits pick one latch and the remaining address bits are ignored.

A port asks for a latch by writing a 0 and gives it up, or withdraws a request it has made, by writing a 1. Each latch keeps track of its current owner and of a request left standing by the other port. When the owner releases the latch, a waiting request takes it over in the same clock. A read returns the latch as the reading port sees it: 0 when that port owns it and 1 otherwise. The value is copied onto every output data line and held in a per-port output register until that port's next read.

Top module: `sem_bank`

## Requirements
- R1: A port accesses the bank at a clock edge only when its select `*_sem_n` is low and its `*_ce_n` is high. A write is `*_we_n` low and a read is `*_we_n` high. When `*_ce_n` is low, the access changes neither the latches nor that port's output register.
- R2: Address bits [2:0] pick one of the eight latches. All higher address bits have no effect.
- R3: Writing 0 to a free latch gives it to the writing port. That port then reads 0 and the other port reads 1. Both ports never own one latch at the same time.
- R4: When the owner writes 1 and the other port has no request standing, the latch becomes free and both ports read 1.
- R5: If the non-owner wrote 0 while the latch was owned, it becomes the owner in the same clock in which the owner writes 1. A read in the next cycle gives it 0.
- R6: A non-owner that writes 1 withdraws its standing request. A later release by the owner then leaves the latch free.
- R7: Writes by the non-owner, whether 0 or 1, never change which port owns the latch.
- R8: A read loads that port's output register with the latch view copied onto all DATA_W lines, so the value is all-zeros or all-ones. The register holds its value through writes from either port until the same port reads again.
- R9: If both ports write 0 to the same free latch in the same clock, the left port wins and the right port's request is kept standing.
- R10: A read in the cycle after a write sees the updated state. A read in the same cycle as the other port's write returns the state from before that write.
- R11: After reset all latches are free and both output registers read all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lft_sem_n | input | 1 | Left semaphore select, active low |
| lft_ce_n | input | 1 | Left memory chip enable, must be high for semaphore access |
| lft_we_n | input | 1 | Left write enable, active low |
| lft_addr | input | PORT_ADDR_W | Left address, low bits pick the latch |
| lft_din | input | 1 | Left write data bit (0 request, 1 release) |
| lft_dout | output | DATA_W | Left registered read data |
| rgt_sem_n | input | 1 | Right semaphore select, active low |
| rgt_ce_n | input | 1 | Right memory chip enable, must be high for semaphore access |
| rgt_we_n | input | 1 | Right write enable, active low |
| rgt_addr | input | PORT_ADDR_W | Right address, low bits pick the latch |
| rgt_din | input | 1 | Right write data bit (0 request, 1 release) |
| rgt_dout | output | DATA_W | Right registered read data |

## Verification
The bench builds the block with its default parameters: eight latches, an 18-line data bus and a 15-bit address. With 15 address bits, accesses can set the ignored upper bits while still hitting a known latch. With 18 data lines, every read can be compared line by line against full replication. Using eight latches lets the bench run the handover, cancel, tie and same-cycle read/write scenarios on separate latches without them interfering.

// File: rtl/sem_pkg.sv
package sem_pkg;

  // Latch ownership encoding
  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_L    = 2'b01,
    OWN_R    = 2'b10
  } owner_e;

endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = 3
) (
  input  logic               sem_n,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic [IDX_W-1:0]   addr,
  output logic [NUM_SEM-1:0] wr_vec,
  output logic               rd_stb,
  output logic [IDX_W-1:0]   idx
);

  logic sel;

  // Semaphore space is live only while the memory enable is inactive
  assign sel    = !sem_n && ce_n;
  assign rd_stb = sel && we_n;
  assign idx    = addr;

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_wr
    assign wr_vec[g] = sel && !we_n && (addr == IDX_W'(g));
  end

endmodule

// File: rtl/sem_latch.sv
module sem_latch
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_l,
  input  logic wr_r,
  input  logic d_l,
  input  logic d_r,
  output logic view_l,
  output logic view_r
);

  logic   req_l_q, req_l_d;
  logic   req_r_q, req_r_d;
  owner_e own_q, own_d;

  // A request flag per side; ownership follows the flags
  always_comb begin
    req_l_d = wr_l ? ~d_l : req_l_q;
    req_r_d = wr_r ? ~d_r : req_r_q;
    unique case (own_q)
      OWN_L: begin
        if (req_l_d)      own_d = OWN_L;
        else if (req_r_d) own_d = OWN_R;
        else              own_d = OWN_NONE;
      end
      OWN_R: begin
        if (req_r_d)      own_d = OWN_R;
        else if (req_l_d) own_d = OWN_L;
        else              own_d = OWN_NONE;
      end
      default: begin
        // Free: fixed left priority on a tie
        if (req_l_d)      own_d = OWN_L;
        else if (req_r_d) own_d = OWN_R;
        else              own_d = OWN_NONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
      own_q   <= OWN_NONE;
    end else begin
      req_l_q <= req_l_d;
      req_r_q <= req_r_d;
      own_q   <= own_d;
    end
  end

  assign view_l = (own_q != OWN_L);
  assign view_r = (own_q != OWN_R);

endmodule

// File: rtl/sem_rd_reg.sv
module sem_rd_reg #(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_SEM-1:0] views,
  output logic [DATA_W-1:0]  dout
);

  logic [DATA_W-1:0] dout_q, dout_d;

  always_comb begin
    dout_d = dout_q;
    if (rd_stb) dout_d = {DATA_W{views[idx]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '1;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;

endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_SEM     = 8,
  parameter int DATA_W      = 18,
  parameter int PORT_ADDR_W = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lft_sem_n,
  input  logic                   lft_ce_n,
  input  logic                   lft_we_n,
  input  logic [PORT_ADDR_W-1:0] lft_addr,
  input  logic                   lft_din,
  output logic [DATA_W-1:0]      lft_dout,
  input  logic                   rgt_sem_n,
  input  logic                   rgt_ce_n,
  input  logic                   rgt_we_n,
  input  logic [PORT_ADDR_W-1:0] rgt_addr,
  input  logic                   rgt_din,
  output logic [DATA_W-1:0]      rgt_dout
);

  localparam int IDX_W = $clog2(NUM_SEM);

  logic [NUM_SEM-1:0] wr_l_vec, wr_r_vec;
  logic [NUM_SEM-1:0] view_l, view_r;
  logic               rd_l, rd_r;
  logic [IDX_W-1:0]   idx_l, idx_r;
  logic               unused_addr_hi;

  assign unused_addr_hi = ^{lft_addr[PORT_ADDR_W-1:IDX_W], rgt_addr[PORT_ADDR_W-1:IDX_W]};

  sem_port_dec #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_l (
    .sem_n (lft_sem_n),
    .ce_n  (lft_ce_n),
    .we_n  (lft_we_n),
    .addr  (lft_addr[IDX_W-1:0]),
    .wr_vec(wr_l_vec),
    .rd_stb(rd_l),
    .idx   (idx_l)
  );

  sem_port_dec #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_r (
    .sem_n (rgt_sem_n),
    .ce_n  (rgt_ce_n),
    .we_n  (rgt_we_n),
    .addr  (rgt_addr[IDX_W-1:0]),
    .wr_vec(wr_r_vec),
    .rd_stb(rd_r),
    .idx   (idx_r)
  );

  for (genvar g = 0; g < NUM_SEM; g++) begin : g_latch
    sem_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_l  (wr_l_vec[g]),
      .wr_r  (wr_r_vec[g]),
      .d_l   (lft_din),
      .d_r   (rgt_din),
      .view_l(view_l[g]),
      .view_r(view_r[g])
    );
  end

  sem_rd_reg #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_l (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_stb(rd_l),
    .idx   (idx_l),
    .views (view_l),
    .dout  (lft_dout)
  );

  sem_rd_reg #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_r (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_stb(rd_r),
    .idx   (idx_r),
    .views (view_r),
    .dout  (rgt_dout)
  );

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lft_sem_n,
  input logic               lft_ce_n,
  input logic               lft_we_n,
  input logic [DATA_W-1:0]  lft_dout,
  input logic               rgt_sem_n,
  input logic               rgt_ce_n,
  input logic               rgt_we_n,
  input logic [DATA_W-1:0]  rgt_dout,
  input logic [NUM_SEM-1:0] view_l,
  input logic [NUM_SEM-1:0] view_r
);

  logic l_read, r_read, any_write;

  assign l_read    = (lft_sem_n == 1'b0) && (lft_ce_n == 1'b1) && (lft_we_n == 1'b1);
  assign r_read    = (rgt_sem_n == 1'b0) && (rgt_ce_n == 1'b1) && (rgt_we_n == 1'b1);
  assign any_write = ((lft_sem_n == 1'b0) && (lft_ce_n == 1'b1) && (lft_we_n == 1'b0)) ||
                     ((rgt_sem_n == 1'b0) && (rgt_ce_n == 1'b1) && (rgt_we_n == 1'b0));

  // R8
  dout_rep_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lft_dout == '0) || (lft_dout == '1));

  // R8
  dout_rep_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgt_dout == '0) || (rgt_dout == '1));

  // R8
  dout_hold_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_read |=> $stable(lft_dout));

  // R8
  dout_hold_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_read |=> $stable(rgt_dout));

  // R3
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    &(view_l | view_r));

  // R1
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_write |=> ($stable(view_l) && $stable(view_r)));

endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_sem_bank_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lft_sem_n(lft_sem_n),
  .lft_ce_n (lft_ce_n),
  .lft_we_n (lft_we_n),
  .lft_dout (lft_dout),
  .rgt_sem_n(rgt_sem_n),
  .rgt_ce_n (rgt_ce_n),
  .rgt_we_n (rgt_we_n),
  .rgt_dout (rgt_dout),
  .view_l   (view_l),
  .view_r   (view_r)
);

// File: tb/sem_bank_bench.sv
module sem_bank_bench;

  localparam int DW = 18;
  localparam int AW = 15;
  localparam int NV = 22;

  // Vector: [6] read, [5] right port, [4:2] latch, [1] write bit, [0] expected read bit
  localparam logic [6:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd2, 1'b0, 1'b0},  // L requests 2
    {1'b1, 1'b0, 3'd2, 1'b0, 1'b0},  // R3 R10 L owns
    {1'b1, 1'b1, 3'd2, 1'b0, 1'b1},  // R3 R sees taken
    {1'b0, 1'b1, 3'd2, 1'b0, 1'b0},  // R requests (pending)
    {1'b1, 1'b1, 3'd2, 1'b0, 1'b1},  // R7
    {1'b1, 1'b0, 3'd2, 1'b0, 1'b0},  // R7
    {1'b0, 1'b1, 3'd2, 1'b1, 1'b0},  // R writes 1 as non-owner
    {1'b1, 1'b0, 3'd2, 1'b0, 1'b0},  // R7
    {1'b0, 1'b1, 3'd2, 1'b0, 1'b0},  // R requests again
    {1'b0, 1'b0, 3'd2, 1'b1, 1'b0},  // L releases
    {1'b1, 1'b1, 3'd2, 1'b0, 1'b0},  // R5 handover
    {1'b1, 1'b0, 3'd2, 1'b0, 1'b1},  // R5
    {1'b0, 1'b1, 3'd2, 1'b1, 1'b0},  // R releases
    {1'b1, 1'b0, 3'd2, 1'b0, 1'b1},  // R4
    {1'b1, 1'b1, 3'd2, 1'b0, 1'b1},  // R4
    {1'b0, 1'b1, 3'd5, 1'b0, 1'b0},  // R requests 5
    {1'b1, 1'b1, 3'd5, 1'b0, 1'b0},  // R3
    {1'b0, 1'b0, 3'd5, 1'b0, 1'b0},  // L pending
    {1'b0, 1'b0, 3'd5, 1'b1, 1'b0},  // L cancels
    {1'b0, 1'b1, 3'd5, 1'b1, 1'b0},  // R releases
    {1'b1, 1'b0, 3'd5, 1'b0, 1'b1},  // R6 stays free
    {1'b1, 1'b1, 3'd5, 1'b0, 1'b1}   // R6
  };

  logic          clk;
  logic          rst_n;
  logic          lft_sem_n, lft_ce_n, lft_we_n, lft_din;
  logic [AW-1:0] lft_addr;
  logic [DW-1:0] lft_dout;
  logic          rgt_sem_n, rgt_ce_n, rgt_we_n, rgt_din;
  logic [AW-1:0] rgt_addr;
  logic [DW-1:0] rgt_dout;

  int checks;
  int errors;
  bit done;

  sem_bank #(.NUM_SEM(8), .DATA_W(DW), .PORT_ADDR_W(AW)) u_sem_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .lft_sem_n(lft_sem_n),
    .lft_ce_n (lft_ce_n),
    .lft_we_n (lft_we_n),
    .lft_addr (lft_addr),
    .lft_din  (lft_din),
    .lft_dout (lft_dout),
    .rgt_sem_n(rgt_sem_n),
    .rgt_ce_n (rgt_ce_n),
    .rgt_we_n (rgt_we_n),
    .rgt_addr (rgt_addr),
    .rgt_din  (rgt_din),
    .rgt_dout (rgt_dout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    lft_sem_n = 1'b1; lft_ce_n = 1'b1; lft_we_n = 1'b1; lft_din = 1'b1; lft_addr = '0;
    rgt_sem_n = 1'b1; rgt_ce_n = 1'b1; rgt_we_n = 1'b1; rgt_din = 1'b1; rgt_addr = '0;
  endtask

  task automatic set_port(input bit rgt, input logic ce_n, input logic we_n,
                          input logic [AW-1:0] addr, input logic d);
    if (rgt) begin
      rgt_sem_n = 1'b0; rgt_ce_n = ce_n; rgt_we_n = we_n; rgt_addr = addr; rgt_din = d;
    end else begin
      lft_sem_n = 1'b0; lft_ce_n = ce_n; lft_we_n = we_n; lft_addr = addr; lft_din = d;
    end
  endtask

  // Drive at a falling edge, let one rising edge take it, return idle at the next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle_all();
  endtask

  task automatic wr(input bit rgt, input logic [AW-1:0] addr, input logic d);
    set_port(rgt, 1'b1, 1'b0, addr, d);
    step();
  endtask

  task automatic rd(input bit rgt, input logic [AW-1:0] addr);
    set_port(rgt, 1'b1, 1'b1, addr, 1'b1);
    step();
  endtask

  function automatic logic [DW-1:0] rep(input logic b);
    return {DW{b}};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    idle_all();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 left dout after reset", lft_dout, rep(1'b1));
    chk("R11 right dout after reset", rgt_dout, rep(1'b1));
    for (int i = 0; i < 8; i++) begin
      rd(1'b0, AW'(i));
      chk("R11 left view of free latch", lft_dout, rep(1'b1));
      rd(1'b1, AW'(i));
      chk("R11 right view of free latch", rgt_dout, rep(1'b1));
    end

    // Table walk (R3 R4 R5 R6 R7 R10)
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][6]) begin
        rd(VEC[v][5], AW'(VEC[v][4:2]));
        chk($sformatf("table vector %0d R3/R4/R5/R6/R7/R10", v),
            VEC[v][5] ? rgt_dout : lft_dout, rep(VEC[v][0]));
      end else begin
        wr(VEC[v][5], AW'(VEC[v][4:2]), VEC[v][1]);
      end
    end

    // R1: request with ce_n low must not take latch 0
    set_port(1'b0, 1'b0, 1'b0, AW'(0), 1'b0);
    step();
    rd(1'b0, AW'(0));
    chk("R1 ce_n low write ignored (left)", lft_dout, rep(1'b1));
    rd(1'b1, AW'(0));
    chk("R1 ce_n low write ignored (right)", rgt_dout, rep(1'b1));

    // R1/R8: left owns 3, reads zeros; a read with ce_n low keeps the register
    wr(1'b0, AW'(3), 1'b0);
    rd(1'b0, AW'(3));
    chk("R8 left reads owned latch as all zeros", lft_dout, rep(1'b0));
    set_port(1'b0, 1'b0, 1'b1, AW'(0), 1'b1);
    step();
    chk("R1 ce_n low read leaves dout", lft_dout, rep(1'b0));

    // R8 hold through writes; R5 handover on release
    wr(1'b1, AW'(3), 1'b0);
    wr(1'b0, AW'(3), 1'b1);
    chk("R8 left dout held through writes", lft_dout, rep(1'b0));
    rd(1'b1, AW'(3));
    chk("R5 right takes latch 3 on release", rgt_dout, rep(1'b0));
    wr(1'b1, AW'(3), 1'b1);

    // R2 upper address bits ignored
    wr(1'b0, 15'h7FF9, 1'b0);
    rd(1'b1, 15'h0001);
    chk("R2 right sees latch 1 taken", rgt_dout, rep(1'b1));
    rd(1'b0, 15'h2229);
    chk("R2 left owns latch 1 via other upper bits", lft_dout, rep(1'b0));
    wr(1'b0, 15'h4001, 1'b1);
    rd(1'b1, 15'h1231);
    chk("R2 latch 1 released", rgt_dout, rep(1'b1));

    // R9 same-cycle tie on latch 7
    set_port(1'b0, 1'b1, 1'b0, AW'(7), 1'b0);
    set_port(1'b1, 1'b1, 1'b0, AW'(7), 1'b0);
    step();
    rd(1'b0, AW'(7));
    chk("R9 left wins tie", lft_dout, rep(1'b0));
    rd(1'b1, AW'(7));
    chk("R9 right loses tie", rgt_dout, rep(1'b1));
    wr(1'b0, AW'(7), 1'b1);
    rd(1'b1, AW'(7));
    chk("R9 right request kept pending", rgt_dout, rep(1'b0));
    wr(1'b1, AW'(7), 1'b1);

    // R10 read in same cycle as the other port's write sees prior state
    set_port(1'b0, 1'b1, 1'b1, AW'(4), 1'b1);
    set_port(1'b1, 1'b1, 1'b0, AW'(4), 1'b0);
    step();
    chk("R10 same-cycle read sees old state", lft_dout, rep(1'b1));
    rd(1'b1, AW'(4));
    chk("R10 next-cycle read sees new owner", rgt_dout, rep(1'b0));
    wr(1'b1, AW'(4), 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule